// File: doc/BRIEF.md
# Interval Counter with Sticky Rollover Flag and Start Synchronisation

This block is the counting core of an interval timer. A counter that idles at 1 advances by one on each qualified tick and, once it has reached a programmable limit, returns to 1 on the next tick. The rollover produces a pulse one clock wide and sets a flag. The flag holds until software clears it. An interrupt line repeats the flag, masked by its own enable.

The tick comes from an upstream prescaler. With the tick tied high, the counter advances on every clock. Several timers can start together. One timer runs as the leader: its own run bit enables it, and it drives that bit out on a sync line. The other timers run as followers: they take their enable from that sync line and ignore their own run bit. Whenever the selected enable is low, the counter is held at its starting value.

Top module: `modcnt_timer`

## Requirements
- R1: After reset, `count` reads 1. While the selected enable is high and `tick` is high, `count` rises by one per clock for as long as it is below `mod_val`, so it walks 1, 2, …, `mod_val`, including the full-scale value.
- R2: A clock with enable and `tick` high, in which `count` is at or above `mod_val`, makes `count` read 1 in the next cycle. In that same cycle `roll_pulse` is high. `roll_pulse` is low in every other cycle.
- R3: `flag` rises in the cycle in which `roll_pulse` is high. It stays high until a clock in which `flag_clr` is 1, and it reads 0 from the next cycle on, provided no rollover happens at that clock.
- R4: When `flag_clr` and a rollover fall on the same clock, `flag` stays high.
- R5: `irq` equals `flag` while `irq_en` is 1 and is 0 while `irq_en` is 0. Dropping `irq_en` leaves `flag` unchanged.
- R6: With `slave_mode` = 1, `sync_in` acts as the enable and `run_en` has no effect on counting. With `slave_mode` = 0, `run_en` acts as the enable and `sync_in` has no effect.
- R7: `sync_out` follows `run_en` in the same cycle, whatever the value of `slave_mode`.
- R8: A clock with the selected enable low makes `count` read 1 in the next cycle, with no pulse and no change to `flag`.
- R9: With `mod_val` equal to 0 or 1, every enabled tick is a rollover, and `count` stays at 1.
- R10: A clock with `tick` low leaves `count` unchanged and produces no pulse.
- R11: If `mod_val` is lowered below the present `count`, the next enabled tick is a rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_val | input | CNT_W | Rollover limit |
| run_en | input | 1 | Local run bit |
| slave_mode | input | 1 | 1 = take the enable from `sync_in` |
| irq_en | input | 1 | Interrupt mask, 1 = pass the flag |
| flag_clr | input | 1 | Clear request for the sticky flag, one clock |
| tick | input | 1 | Count qualifier from the prescaler |
| sync_in | input | 1 | Enable from a leader timer |
| count | output | CNT_W | Present counter value |
| roll_pulse | output | 1 | One-clock rollover pulse |
| flag | output | 1 | Sticky rollover flag |
| irq | output | 1 | Masked interrupt |
| sync_out | output | 1 | Run bit for follower timers |

## Verification
The bench builds the block with `CNT_W` = 4. At that width the full-scale limit of 15 can be reached in a few clocks, so the bench can show that the counter stops at that limit and never wraps through zero. The narrow width also keeps short the sequence that lowers the limit below a running count. Limits of 0, 1 and 5 cover the degenerate cases and the ordinary case. The bench sets the leader and follower enable sources against each other so that the unselected source is shown to have no effect.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [0:0] {
        SRC_LOCAL = 1'b0,
        SRC_EXT   = 1'b1
    } en_src_e;

    typedef struct packed {
        logic flag;
    } flag_st_t;

endpackage

// File: rtl/tmr_en_sel.sv
module tmr_en_sel
    import tmr_pkg::*;
(
    input  logic run_en,
    input  logic slave_mode,
    input  logic sync_in,
    output logic cnt_en,
    output logic sync_out
);

    en_src_e src;

    always_comb begin
        src = slave_mode ? SRC_EXT : SRC_LOCAL;
        unique case (src)
            SRC_EXT:   cnt_en = sync_in;
            default:   cnt_en = run_en;
        endcase
        sync_out = run_en;
    end

endmodule

// File: rtl/tmr_main_cnt.sv
module tmr_main_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             tick,
    input  logic [CNT_W-1:0] mod_val,
    output logic [CNT_W-1:0] count,
    output logic             roll_pulse,
    output logic             roll_evt
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        roll_evt   = 1'b0;
        if (!cnt_en) begin
            st_d.cnt = CNT_ONE;
        end else if (tick) begin
            if (st_q.cnt >= mod_val) begin
                st_d.cnt   = CNT_ONE;
                st_d.pulse = 1'b1;
                roll_evt   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: CNT_ONE, pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign count      = st_q.cnt;
    assign roll_pulse = st_q.pulse;

    // R1: the counter never holds zero
    assert_never_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt != '0);

    // R1: an enabled tick below the limit steps by one
    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && tick && (st_q.cnt < mod_val)) |=> (st_q.cnt == $past(st_q.cnt) + CNT_ONE));

    // R2: the pulse appears only together with a restarted count
    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> (st_q.cnt == CNT_ONE));

    // R8: a low enable parks the counter at one, without a pulse
    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> (st_q.cnt == CNT_ONE) && !st_q.pulse);

    // R10: no tick, no motion
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !tick) |=> ($stable(st_q.cnt) && !st_q.pulse));

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic roll_evt,
    input  logic flag_clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (roll_evt) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
    assign irq  = st_q.flag & irq_en;

    // R3: the flag holds until a clear is requested
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !flag_clr) |=> st_q.flag);

    // R3: a clear with no rollover drops the flag
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !roll_evt) |=> !st_q.flag);

    // R4: a rollover sets the flag even against a clear
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        roll_evt |=> st_q.flag);

endmodule

// File: rtl/modcnt_timer.sv
module modcnt_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] mod_val,
    input  logic             run_en,
    input  logic             slave_mode,
    input  logic             irq_en,
    input  logic             flag_clr,
    input  logic             tick,
    input  logic             sync_in,
    output logic [CNT_W-1:0] count,
    output logic             roll_pulse,
    output logic             flag,
    output logic             irq,
    output logic             sync_out
);

    logic cnt_en;
    logic roll_evt;

    tmr_en_sel u_en_sel (
        .run_en     (run_en),
        .slave_mode (slave_mode),
        .sync_in    (sync_in),
        .cnt_en     (cnt_en),
        .sync_out   (sync_out)
    );

    tmr_main_cnt #(.CNT_W(CNT_W)) u_main_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .tick       (tick),
        .mod_val    (mod_val),
        .count      (count),
        .roll_pulse (roll_pulse),
        .roll_evt   (roll_evt)
    );

    tmr_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .roll_evt (roll_evt),
        .flag_clr (flag_clr),
        .irq_en   (irq_en),
        .flag     (flag),
        .irq      (irq)
    );

    // R3: the flag is up whenever a pulse is out
    assert_pulse_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        roll_pulse |-> flag);

    // R6: a follower with its sync line low stays parked at one
    assert_follower_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && !sync_in) |=> (count == CNT_W'(1)) && !roll_pulse);

    // R6: a leader with its run bit low stays parked at one
    assert_leader_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !run_en) |=> (count == CNT_W'(1)) && !roll_pulse);

endmodule

// File: tb/modcnt_timer_tb.sv
module modcnt_timer_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] mod_val = '0;
    logic         run_en = 1'b0, slave_mode = 1'b0, irq_en = 1'b0;
    logic         flag_clr = 1'b0, tick = 1'b0, sync_in = 1'b0;
    logic [W-1:0] count;
    logic         roll_pulse, flag, irq, sync_out;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [W-1:0] cnt;
        logic         pulse;
        logic         flg;
        string        tag;
    } exp_t;

    exp_t exp_q[$];

    logic [W-1:0] m_cnt = 4'd1;
    logic         m_flag = 1'b0;

    always #4 clk = ~clk;

    modcnt_timer #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mod_val(mod_val), .run_en(run_en),
        .slave_mode(slave_mode), .irq_en(irq_en), .flag_clr(flag_clr),
        .tick(tick), .sync_in(sync_in), .count(count), .roll_pulse(roll_pulse),
        .flag(flag), .irq(irq), .sync_out(sync_out)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // driver: one clock of stimulus plus its expected outcome
    task automatic cyc(input logic [W-1:0] m, input logic run, input logic slv,
                       input logic sy, input logic ie, input logic clr,
                       input logic tk, input string tag);
        logic en;
        logic roll;
        exp_t e;
        @(posedge clk);
        #1;
        mod_val = m; run_en = run; slave_mode = slv; sync_in = sy;
        irq_en = ie; flag_clr = clr; tick = tk;
        #1;
        chk("R7 sync_out", W'(sync_out), W'(run));
        chk("R5 irq", W'(irq), W'(m_flag & ie));
        en   = slv ? sy : run;
        roll = 1'b0;
        if (!en) begin
            m_cnt = 4'd1;
        end else if (tk) begin
            if (m_cnt >= m) begin
                m_cnt = 4'd1;
                roll  = 1'b1;
            end else begin
                m_cnt = m_cnt + 4'd1;
            end
        end
        m_flag = roll | (m_flag & ~clr);
        e.cnt = m_cnt; e.pulse = roll; e.flg = m_flag; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compares the state seen after each clock against the queue
    always @(posedge clk) begin
        int n;
        exp_t e;
        n = exp_q.size();
        #4;
        if (n > 0) begin
            e = exp_q.pop_front();
            chk({e.tag, " count"}, count, e.cnt);
            chk({e.tag, " roll_pulse"}, W'(roll_pulse), W'(e.pulse));
            chk({e.tag, " flag"}, W'(flag), W'(e.flg));
        end
    end

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset count", count, 4'd1);
        chk("R2 reset pulse", W'(roll_pulse), 4'd0);
        chk("R3 reset flag", W'(flag), 4'd0);
        chk("R5 reset irq", W'(irq), 4'd0);

        // limit 5, tick every clock
        for (int i = 0; i < 12; i++) cyc(4'd5, 1, 0, 0, 0, 0, 1, "R2");
        // clear, then interrupt masking
        cyc(4'd5, 1, 0, 0, 1, 1, 1, "R3");
        for (int i = 0; i < 5; i++) cyc(4'd5, 1, 0, 0, 1, 0, 1, "R5");
        for (int i = 0; i < 3; i++) cyc(4'd5, 1, 0, 0, 0, 0, 1, "R5");
        // sparse ticks
        for (int i = 0; i < 10; i++) cyc(4'd5, 1, 0, 1, 1, 0, 1'(i % 2), "R10");
        // disable mid-count
        cyc(4'd5, 1, 0, 0, 1, 0, 1, "R8");
        cyc(4'd5, 0, 0, 1, 1, 0, 1, "R8");
        cyc(4'd5, 0, 0, 1, 1, 0, 1, "R8");
        // full-scale limit
        for (int i = 0; i < 17; i++) cyc(4'd15, 1, 0, 0, 1, 0, 1, "R1");
        // limit lowered below a running count
        for (int i = 0; i < 9; i++) cyc(4'd15, 1, 0, 0, 1, 1, 1, "R11");
        for (int i = 0; i < 4; i++) cyc(4'd3, 1, 0, 0, 1, 0, 1, "R11");
        // degenerate limits and clear against rollover
        for (int i = 0; i < 5; i++) cyc(4'd1, 1, 0, 0, 1, 0, 1, "R9");
        cyc(4'd1, 1, 0, 0, 1, 1, 1, "R4");
        for (int i = 0; i < 4; i++) cyc(4'd0, 1, 0, 0, 1, 0, 1, "R9");
        cyc(4'd0, 1, 0, 0, 1, 1, 0, "R3");
        // follower: sync low, run high -> parked
        for (int i = 0; i < 4; i++) cyc(4'd4, 1, 1, 0, 1, 0, 1, "R6");
        // follower: sync high, run low -> counts
        for (int i = 0; i < 9; i++) cyc(4'd4, 0, 1, 1, 1, 0, 1, "R6");
        cyc(4'd4, 0, 1, 0, 1, 1, 1, "R6");

        repeat (3) @(posedge clk);
        #6;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule